// File: doc/BRIEF.md
# Pipelined Burst Static Memory

This block is a single-port synchronous memory with registered inputs and a pipelined read path. Every control, address and data input is captured on the rising clock edge. A new access begins when one of two address strobes is taken. The processor-side strobe always starts a read and only counts while chip select is low. The controller-side strobe can start a read or a write, and with chip select high it deselects the memory.

After an address is loaded, an internal burst sequencer walks through a four-word block. The sequencer can step in a linear order or an interleaved order, and an advance input either steps it or holds it in place to insert wait states. The word is split into byte lanes of 9 bits each. Writes cover the full word under a global write input, or selected lanes under a byte-write master enable. Read data leaves through an output register one cycle after the address. An asynchronous output-enable gates the valid flag.

A sleep input turns off input sampling after a fixed two-edge latency and keeps the array contents. The memory depth, lane count and width, burst length and sleep latency are all parameters.

Top module: `burst_sram_core`

## Requirements
- R1: When `pstb_n_i`=0 and `cs_n_i`=0 on an edge, `addr_i` is loaded and a read starts. The write controls on that edge are ignored, and the stored word does not change.
- R2: With `cs_n_i`=1, `pstb_n_i` is ignored. `cstb_n_i`=0 with `cs_n_i`=1 deselects the memory, and `rvalid_o` is 0 after the following edge.
- R3: When `cstb_n_i`=0, `cs_n_i`=0 and `pstb_n_i`=1, `addr_i` is loaded. The access is a write if a write is requested and a read otherwise.
- R4: A write is requested when `gwr_n_i`=0, which writes all lanes. A write is also requested when `bwe_n_i`=0 and at least one `bsel_n_i[i]`=0; each such lane i (bits 9i+8..9i) is written. With `gwr_n_i`=1 and `bwe_n_i`=1, nothing is written.
- R5: With both strobes inactive and `adv_n_i`=0, the burst steps to the next address. A write on that edge goes to the new address. For start low bits s and step c, the low two address bits are (s+c) mod 4 when `burst_lin_i`=1 and s XOR c when `burst_lin_i`=0. The upper bits stay fixed, and after four steps the burst wraps to s.
- R6: With both strobes inactive and `adv_n_i`=1, the address is held. A write on that edge goes to the held address. Without a write, a read repeats only if the previous cycle was a read.
- R7: A read's data appears on `rdata_o`, with `rvalid_o`=1, after the edge following the one that registered its address.
- R8: A write requested on the edge right after a processor-strobe read, with `adv_n_i`=1, writes the address that the read loaded.
- R9: After a write, `rvalid_o` stays 0 until a strobe read or an advancing read occurs.
- R10: `oe_n_i`=1 forces `rvalid_o` to 0 at once, without a clock edge, and leaves `rdata_o` unchanged.
- R11: The sleep gate follows `sleep_i` two edges late. The first two edges after `sleep_i` rises still sample the inputs. While the gate is active, all other inputs are ignored, `rvalid_o` goes to 0 and the memory is deselected. The first two edges after `sleep_i` falls are still ignored. Stored data is kept throughout.
- R12: After reset, `rvalid_o` is 0 and the memory is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| sleep_i | input | 1 | Active-high sleep request |
| burst_lin_i | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| cs_n_i | input | 1 | Active-low chip select |
| pstb_n_i | input | 1 | Processor-side address strobe, active low |
| cstb_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwr_n_i | input | 1 | Global full-word write, active low |
| bwe_n_i | input | 1 | Byte-write master enable, active low |
| bsel_n_i | input | LANES | Per-lane write select, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rvalid_o | output | 1 | Read data valid, gated by output enable |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge. They also assume that the burst order input changes only while the memory is deselected, and that sleep is never raised while a multi-cycle access still depends on later edges. The stimulus switches the burst order only after a deselect cycle. During sleep entry it issues only single-edge writes, which complete on the edge that takes them, so the dropped-operation case is never relied on. Every expected word comes from a bench-side copy of the array that is updated arithmetically from the writes the bench issues.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   // What the read pipeline does on the current edge
   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_NEW  = 2'd1,
      RD_KEEP = 2'd2
   } rd_act_e;

   // Decoded command for one edge
   typedef struct packed {
      logic    load;
      logic    desel;
      logic    step;
      logic    wr;
      rd_act_e rd;
   } bsram_cmd_t;

endpackage

// File: rtl/bsram_sleep_gate.sv
module bsram_sleep_gate #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   output logic gate_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bsram_sleep_gate: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], sleep_i};
   end

   assign gate_o = sh_q[STAGES-1];

endmodule

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq #(
   parameter int AW = 6,
   parameter int BB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          step_i,
   input  logic [AW-1:0] load_addr_i,
   input  logic          lin_i,
   output logic [AW-1:0] cur_addr_o,
   output logic [AW-1:0] nxt_addr_o
);

   generate
      if (BB >= AW) begin : g_bad_bb
         $error("bsram_burst_seq: BB must be below AW");
      end

      if (BB == 0) begin : g_flat
         logic [AW-1:0] base_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      base_q <= '0;
            else if (load_i) base_q <= load_addr_i;
         end
         assign cur_addr_o = base_q;
         assign nxt_addr_o = base_q;
      end else begin : g_burst
         logic [AW-1:0] base_q;
         logic [BB-1:0] cnt_q;
         logic [BB-1:0] cnt_nx;

         function automatic logic [BB-1:0] order(input logic [BB-1:0] s,
                                                 input logic [BB-1:0] c,
                                                 input logic          lin);
            return lin ? BB'(s + c) : (s ^ c);
         endfunction

         assign cnt_nx = BB'(cnt_q + 1'b1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_q <= '0;
               cnt_q  <= '0;
            end else if (load_i) begin
               base_q <= load_addr_i;
               cnt_q  <= '0;
            end else if (step_i) begin
               cnt_q  <= cnt_nx;
            end
         end

         assign cur_addr_o = {base_q[AW-1:BB], order(base_q[BB-1:0], cnt_q, lin_i)};
         assign nxt_addr_o = {base_q[AW-1:BB], order(base_q[BB-1:0], cnt_nx, lin_i)};

         // R5
         step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step_i && !load_i) |=> (cnt_q == BB'($past(cnt_q) + 1'b1)));

         // R5
         load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> ((cnt_q == '0) && (cur_addr_o == $past(load_addr_i))));
      end
   endgenerate

endmodule

// File: rtl/bsram_cmd_decode.sv
module bsram_cmd_decode
   import bsram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             active_i,
   input  logic             gate_i,
   input  logic             cs_n_i,
   input  logic             pstb_n_i,
   input  logic             cstb_n_i,
   input  logic             adv_n_i,
   input  logic             gwr_n_i,
   input  logic             bwe_n_i,
   input  logic [LANES-1:0] bsel_n_i,
   output bsram_cmd_t       cmd_o,
   output logic [LANES-1:0] lane_we_o
);

   logic wr_req;

   assign wr_req = !gwr_n_i || (!bwe_n_i && !(&bsel_n_i));

   always_comb begin
      cmd_o    = '0;
      cmd_o.rd = RD_NONE;
      if (gate_i) begin
         cmd_o.rd = RD_NONE;
      end else if (!pstb_n_i && !cs_n_i) begin
         cmd_o.load = 1'b1;
         cmd_o.rd   = RD_NEW;
      end else if (!cstb_n_i && cs_n_i) begin
         cmd_o.desel = 1'b1;
      end else if (!cstb_n_i) begin
         cmd_o.load = 1'b1;
         cmd_o.wr   = wr_req;
         cmd_o.rd   = wr_req ? RD_NONE : RD_NEW;
      end else if (active_i) begin
         cmd_o.step = !adv_n_i;
         cmd_o.wr   = wr_req;
         if (wr_req)         cmd_o.rd = RD_NONE;
         else if (!adv_n_i)  cmd_o.rd = RD_NEW;
         else                cmd_o.rd = RD_KEEP;
      end
   end

   always_comb begin
      if (!cmd_o.wr)     lane_we_o = '0;
      else if (!gwr_n_i) lane_we_o = '1;
      else               lane_we_o = ~bsel_n_i;
   end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
   import bsram_pkg::*;
#(
   parameter int AW           = 6,
   parameter int LANES        = 4,
   parameter int LANE_W       = 9,
   parameter int BURST_BITS   = 2,
   parameter int SLEEP_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sleep_i,
   input  logic                     burst_lin_i,
   input  logic                     cs_n_i,
   input  logic                     pstb_n_i,
   input  logic                     cstb_n_i,
   input  logic                     adv_n_i,
   input  logic                     gwr_n_i,
   input  logic                     bwe_n_i,
   input  logic [LANES-1:0]         bsel_n_i,
   input  logic [AW-1:0]            addr_i,
   input  logic [LANES*LANE_W-1:0]  wdata_i,
   input  logic                     oe_n_i,
   output logic [LANES*LANE_W-1:0]  rdata_o,
   output logic                     rvalid_o
);

   localparam int DW    = LANES * LANE_W;
   localparam int DEPTH = 1 << AW;

   generate
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("burst_sram_core: LANES and LANE_W must be positive");
      end
      if (BURST_BITS >= AW) begin : g_bad_burst
         $error("burst_sram_core: BURST_BITS must be below AW");
      end
      if (SLEEP_STAGES < 2) begin : g_bad_sleep
         $error("burst_sram_core: SLEEP_STAGES must be at least 2");
      end
   endgenerate

   logic             sleep_gate;
   bsram_cmd_t       cmd;
   logic [LANES-1:0] lane_we;
   logic             active_q;
   logic             rd_q;
   logic             dvalid_q;
   logic [AW-1:0]    cur_addr;
   logic [AW-1:0]    nxt_addr;
   logic [AW-1:0]    wr_addr;

   bsram_sleep_gate #(.STAGES(SLEEP_STAGES)) u_sleep (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep_i (sleep_i),
      .gate_o  (sleep_gate)
   );

   bsram_cmd_decode #(.LANES(LANES)) u_dec (
      .active_i  (active_q),
      .gate_i    (sleep_gate),
      .cs_n_i    (cs_n_i),
      .pstb_n_i  (pstb_n_i),
      .cstb_n_i  (cstb_n_i),
      .adv_n_i   (adv_n_i),
      .gwr_n_i   (gwr_n_i),
      .bwe_n_i   (bwe_n_i),
      .bsel_n_i  (bsel_n_i),
      .cmd_o     (cmd),
      .lane_we_o (lane_we)
   );

   bsram_burst_seq #(.AW(AW), .BB(BURST_BITS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (cmd.load),
      .step_i      (cmd.step),
      .load_addr_i (addr_i),
      .lin_i       (burst_lin_i),
      .cur_addr_o  (cur_addr),
      .nxt_addr_o  (nxt_addr)
   );

   always_comb begin
      if (cmd.load)      wr_addr = addr_i;
      else if (cmd.step) wr_addr = nxt_addr;
      else               wr_addr = cur_addr;
   end

   // Access state and read pipeline
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
         dvalid_q <= 1'b0;
      end else begin
         if (sleep_gate || cmd.desel) active_q <= 1'b0;
         else if (cmd.load)           active_q <= 1'b1;

         case (cmd.rd)
            RD_NEW:  rd_q <= 1'b1;
            RD_KEEP: rd_q <= rd_q;
            default: rd_q <= 1'b0;
         endcase

         dvalid_q <= sleep_gate ? 1'b0 : rd_q;
      end
   end

   // One storage column and output register per lane
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem_q [DEPTH];
         logic [LANE_W-1:0] dout_q;

         always_ff @(posedge clk) begin
            if (lane_we[g]) mem_q[wr_addr] <= wdata_i[g*LANE_W +: LANE_W];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    dout_q <= '0;
            else if (rd_q) dout_q <= mem_q[cur_addr];
         end

         assign rdata_o[g*LANE_W +: LANE_W] = dout_q;
      end
   endgenerate

   assign rvalid_o = dvalid_q && !oe_n_i;

   // R1
   pread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_gate && !cs_n_i && !pstb_n_i) |=> (rd_q && active_q));

   // R1
   pread_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_gate && !cs_n_i && !pstb_n_i) |-> (lane_we == '0));

   // R2
   deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_gate && cs_n_i && !cstb_n_i) |=> (!rd_q && !active_q));

   // R7
   pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && !sleep_gate) |=> dvalid_q);

   // R9
   wr_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_we) |=> !rd_q);

   // R11
   sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_gate |=> (!dvalid_q && !active_q && !rd_q));

   // R11
   sleep_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_gate |-> (lane_we == '0));

   logic unused_dw;
   assign unused_dw = (DW == 0);

endmodule

// File: tb/burst_sram_core_test.sv
module burst_sram_core_test;

   localparam int AW = 6;
   localparam int LN = 4;
   localparam int LW = 9;
   localparam int DW = LN * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_i = 1'b0;
   logic          burst_lin_i = 1'b0;
   logic          cs_n_i, pstb_n_i, cstb_n_i, adv_n_i, gwr_n_i, bwe_n_i;
   logic [LN-1:0] bsel_n_i;
   logic [AW-1:0] addr_i;
   logic [DW-1:0] wdata_i;
   logic          oe_n_i = 1'b0;
   logic [DW-1:0] rdata_o;
   logic          rvalid_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [DW-1:0] ref_mem [64];

   burst_sram_core uut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .burst_lin_i(burst_lin_i),
      .cs_n_i(cs_n_i), .pstb_n_i(pstb_n_i), .cstb_n_i(cstb_n_i), .adv_n_i(adv_n_i),
      .gwr_n_i(gwr_n_i), .bwe_n_i(bwe_n_i), .bsel_n_i(bsel_n_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .oe_n_i(oe_n_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
   );

   always #5 clk = ~clk;

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      logic [63:0] v;
      v = 64'(a) * 64'h9E3779B1 + 64'(salt) * 64'h7F4A7C15;
      return DW'(v) ^ 36'hA5A5A5A5A;
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [LN-1:0] mask);
      logic [DW-1:0] r;
      r = old_w;
      for (int l = 0; l < LN; l++)
         if (mask[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_rd(input string tag, input logic [DW-1:0] exp);
      chk({tag, " valid"}, DW'(rvalid_o), DW'(1));
      chk(tag, rdata_o, exp);
   endtask

   task automatic chk_off(input string tag);
      chk({tag, " off"}, DW'(rvalid_o), DW'(0));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drv_idle();
      cs_n_i = 1; pstb_n_i = 1; cstb_n_i = 1; adv_n_i = 1;
      gwr_n_i = 1; bwe_n_i = 1; bsel_n_i = '1; addr_i = '0; wdata_i = '0;
   endtask

   task automatic c_idle();
      drv_idle(); tick();
   endtask

   task automatic c_desel();
      drv_idle(); cstb_n_i = 0; tick();
   endtask

   task automatic c_pread(input int a, input logic gw);
      drv_idle(); cs_n_i = 0; pstb_n_i = 0; addr_i = AW'(a);
      gwr_n_i = gw; wdata_i = '1; tick();
   endtask

   task automatic c_cread(input int a);
      drv_idle(); cs_n_i = 0; cstb_n_i = 0; addr_i = AW'(a); tick();
   endtask

   task automatic c_cwrite(input int a, input logic [DW-1:0] d);
      drv_idle(); cs_n_i = 0; cstb_n_i = 0; addr_i = AW'(a);
      gwr_n_i = 0; wdata_i = d; tick();
   endtask

   task automatic c_cbyte(input int a, input logic [DW-1:0] d,
                          input logic [LN-1:0] sel_n, input logic bwe);
      drv_idle(); cs_n_i = 0; cstb_n_i = 0; addr_i = AW'(a);
      bwe_n_i = bwe; bsel_n_i = sel_n; wdata_i = d; tick();
   endtask

   task automatic c_adv(input logic adv, input logic gw, input logic [DW-1:0] d);
      drv_idle(); adv_n_i = adv; gwr_n_i = gw; wdata_i = d; tick();
   endtask

   task automatic read_range(input int lo, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         c_cread(lo + i);
         if (i > 0) chk_rd(tag, ref_mem[lo + i - 1]);
      end
      c_desel();
      chk_rd(tag, ref_mem[lo + n - 1]);
      c_idle();
      chk_off(tag);
   endtask

   function automatic int burst_addr(input int base, input int s, input int c, input bit lin);
      return base + (lin ? ((s + c) & 3) : (s ^ (c & 3)));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      drv_idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: quiet after reset
      chk_off("R12");
      c_idle(); c_idle();
      chk_off("R12 idle");

      // R3 R4: fill with global writes, then read back with controller strobe
      for (int a = 0; a < 64; a++) begin
         ref_mem[a] = pat(a, 1);
         c_cwrite(a, ref_mem[a]);
      end
      c_desel();
      read_range(0, 64, "R3 fill");

      // R5: both burst orders, every start offset, wrap after four
      for (int lin = 0; lin < 2; lin++) begin
         burst_lin_i = lin[0];
         for (int s = 0; s < 4; s++) begin
            c_pread(16 + s, 1'b1);
            for (int c = 1; c <= 4; c++) begin
               c_adv(1'b0, 1'b1, '0);
               chk_rd("R5 burst", ref_mem[burst_addr(16, s, c - 1, lin[0])]);
            end
            c_desel();
            chk_rd("R5 wrap", ref_mem[burst_addr(16, s, 4, lin[0])]);
            c_idle();
            chk_off("R2 after burst");
         end
      end
      burst_lin_i = 1'b0;
      c_idle();

      // R6: suspend repeats the held address, then advance
      c_pread(40, 1'b1);
      c_adv(1'b1, 1'b1, '0);
      chk_rd("R6 hold", ref_mem[40]);
      c_adv(1'b1, 1'b1, '0);
      chk_rd("R6 hold", ref_mem[40]);
      c_adv(1'b0, 1'b1, '0);
      chk_rd("R6 hold", ref_mem[40]);
      c_desel();
      chk_rd("R6 step", ref_mem[41]);
      c_idle();
      chk_off("R6");

      // R1: processor strobe ignores a global write request
      c_pread(5, 1'b0);
      c_desel();
      chk_rd("R1", ref_mem[5]);
      c_idle();
      read_range(5, 1, "R1 unchanged");

      // R2: processor strobe with chip select high is ignored
      c_pread(20, 1'b1);
      drv_idle(); cs_n_i = 0; cs_n_i = 1; pstb_n_i = 0; adv_n_i = 0; addr_i = 6'd50; tick();
      chk_rd("R2 ignored", ref_mem[20]);
      c_desel();
      chk_rd("R2 continued", ref_mem[21]);
      c_idle();
      chk_off("R2");
      c_pread(22, 1'b1);
      drv_idle(); cs_n_i = 1; pstb_n_i = 0; cstb_n_i = 0; addr_i = 6'd3; tick();
      chk_rd("R2 last", ref_mem[22]);
      c_idle();
      chk_off("R2 desel");

      // R8 R9: write right after processor read, output stays off
      c_pread(30, 1'b1);
      drv_idle(); bwe_n_i = 0; bsel_n_i = 4'b1110; wdata_i = pat(30, 7); tick();
      chk_rd("R8 read before write", ref_mem[30]);
      ref_mem[30] = merge(ref_mem[30], pat(30, 7), 4'b0001);
      c_idle();
      chk_off("R9");
      c_idle();
      chk_off("R9");
      c_adv(1'b0, 1'b1, '0);
      chk_off("R9");
      c_desel();
      chk_rd("R9 advance read", ref_mem[31]);
      c_idle();
      read_range(30, 1, "R8");

      // R4: every lane mask with byte writes, plus master enable off
      for (int m = 0; m < 16; m++) begin
         c_cbyte(m, pat(m, 3), ~m[3:0], 1'b0);
         ref_mem[m] = merge(ref_mem[m], pat(m, 3), m[3:0]);
      end
      c_cbyte(16, pat(16, 3), 4'b0000, 1'b1);
      c_desel();
      read_range(0, 17, "R4 lanes");

      // R5 R6: burst writes step and hold
      c_cwrite(44, pat(44, 5));
      c_adv(1'b0, 1'b0, pat(45, 5));
      c_adv(1'b1, 1'b0, pat(45, 6));
      c_adv(1'b0, 1'b0, pat(46, 5));
      ref_mem[44] = pat(44, 5);
      ref_mem[45] = pat(45, 6);
      ref_mem[46] = pat(46, 5);
      c_desel();
      read_range(44, 3, "R5 write");

      // R10: output enable gates valid only
      c_pread(7, 1'b1);
      oe_n_i = 1'b1;
      c_desel();
      chk_off("R10");
      chk("R10 data", rdata_o, ref_mem[7]);
      oe_n_i = 1'b0;
      #1;
      chk_rd("R10", ref_mem[7]);
      c_idle();

      // R11: sleep with two-edge latency each way
      sleep_i = 1'b1;
      c_cwrite(60, pat(60, 9));
      c_cwrite(61, pat(61, 9));
      ref_mem[60] = pat(60, 9);
      ref_mem[61] = pat(61, 9);
      c_cwrite(62, pat(62, 9));
      chk_off("R11");
      c_pread(63, 1'b1);
      c_idle();
      chk_off("R11 read ignored");
      sleep_i = 1'b0;
      c_cwrite(62, pat(62, 10));
      c_cwrite(63, pat(63, 10));
      c_desel();
      read_range(60, 4, "R11");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule